// File: doc/BRIEF.md
# Flash Status Polling Word Generator

This block forms the word a host sees when it reads a flash array while an embedded program or erase operation is running, has been suspended, or has stopped with an error. It takes the controller's state flags and the read address's block index. It returns either an 8-bit status word or a select flag. The select flag tells the surrounding data path to return ordinary array contents instead.

Software polls the word in two ways. It can compare bit 7 against the data it expects. It can also watch bits 6 and 2, which change on each read strobe while work is still in progress. Bit 5 reports a failure. Bit 3 shows whether an erase has actually begun or is still accepting more blocks. Bit 2 also pinpoints failing blocks after an erase error.

Top module: `flash_status_poll`

## Requirements
- R1: When busy, suspended and error flags are all low, `array_sel` is 1 and `status_word` is 8'h00.
- R2: While busy with a program (`op_is_erase`=0), `array_sel` is 0, bit 7 equals the inverse of `prog_dq7`, and bit 3 is 0.
- R3: While busy with an erase (`op_is_erase`=1), bit 7 is 0.
- R4: While busy, bit 6 inverts after each cycle with `rd_strobe` high, whatever block is addressed.
- R5: While suspended (busy and error low), or in the error state, bit 6 holds its value across read strobes.
- R6: While suspended, a read whose block is set in `erasing_mask` gives status with bit 7 = 1. A read of any other block, including an index of `NUM_BLOCKS` or more, gives `array_sel` = 1 and a zero word.
- R7: Whenever status is returned, bit 5 equals `error_flag`. With busy low and `error_flag` high, status keeps being returned (`array_sel`=0), and bit 7 follows the rule of the operation type (R2/R3).
- R8: During an erase, bit 3 equals `erase_started`: 0 while blocks can still be added, 1 once erasing has begun.
- R9: During an erase, busy or suspended, bit 2 inverts on each strobed read of a block set in `erasing_mask`. It holds on reads of other blocks and throughout a program.
- R10: In the error state after an erase, bit 2 inverts only on strobed reads of blocks set in `failed_mask`, and holds for every other block.
- R11: Bits 4, 1 and 0 of `status_word` are always 0.
- R12: A cycle with `op_start` high clears both toggle bits (6 and 2) to 0, and takes priority over a simultaneous read strobe.
- R13: After reset both toggle bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Pulse at the start of a new program or erase |
| op_is_erase | input | 1 | 1 = erase, 0 = program |
| busy | input | 1 | Embedded operation running |
| suspended | input | 1 | Erase suspended |
| erase_started | input | 1 | Erase has begun (block list closed) |
| error_flag | input | 1 | Operation failed |
| prog_dq7 | input | 1 | Bit 7 of the data being programmed |
| erasing_mask | input | NUM_BLOCKS | Blocks selected for erase |
| failed_mask | input | NUM_BLOCKS | Blocks that failed to erase |
| rd_blk | input | $clog2(NUM_BLOCKS) | Block index of the read address |
| rd_strobe | input | 1 | One cycle per host read; advances toggle bits |
| status_word | output | 8 | Status returned to the host |
| array_sel | output | 1 | 1 = data path returns array data |

## Verification
A vector table sweeps the static bits across several states: idle, program with either data polarity, erase before and after the start flag, suspend inside and outside the erasing set, an out-of-range block index, and errors after both operation types. This separates the bit 7 and bit 3 rules and the array/status choice. Directed sequences then strobe reads while the mode and the addressed block change. Bit 6 must follow the busy state only. Bit 2 must follow the erasing set during erase and suspend, and the failed set after an error. Restart pulses must zero both toggles.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [1:0] {
    FSP_IDLE   = 2'd0,
    FSP_ACTIVE = 2'd1,
    FSP_SUSP   = 2'd2,
    FSP_FAULT  = 2'd3
  } fsp_mode_e;

  localparam int unsigned FSP_BIT_POLL   = 7;
  localparam int unsigned FSP_BIT_TOG    = 6;
  localparam int unsigned FSP_BIT_ERR    = 5;
  localparam int unsigned FSP_BIT_TIMER  = 3;
  localparam int unsigned FSP_BIT_ALTTOG = 2;
  localparam int unsigned FSP_NUM_TOG    = 2;
  localparam int unsigned FSP_TOG_MAIN   = 0;
  localparam int unsigned FSP_TOG_ALT    = 1;
endpackage

// File: rtl/fsp_rst_sync.sv
module fsp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fsp_block_lookup.sv
module fsp_block_lookup #(
  parameter int unsigned NUM_BLOCKS = 11,
  localparam int unsigned IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic [NUM_BLOCKS-1:0] erasing_mask,
  input  logic [NUM_BLOCKS-1:0] failed_mask,
  input  logic [IDX_W-1:0]      rd_blk,
  output logic                  hit_erasing,
  output logic                  hit_failed
);
  logic [NUM_BLOCKS-1:0] blk_match;

  for (genvar gi = 0; gi < NUM_BLOCKS; gi++) begin : g_match
    assign blk_match[gi] = (rd_blk == IDX_W'(gi));
  end

  assign hit_erasing = |(blk_match & erasing_mask);
  assign hit_failed  = |(blk_match & failed_mask);
endmodule

// File: rtl/fsp_mode_decode.sv
module fsp_mode_decode
  import fsp_pkg::*;
(
  input  logic      busy,
  input  logic      suspended,
  input  logic      error_flag,
  output fsp_mode_e mode
);
  always_comb begin
    if (busy)            mode = FSP_ACTIVE;
    else if (error_flag) mode = FSP_FAULT;
    else if (suspended)  mode = FSP_SUSP;
    else                 mode = FSP_IDLE;
  end
endmodule

// File: rtl/fsp_toggle_bit.sv
module fsp_toggle_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic q
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = clr | adv;
    q_d  = clr ? 1'b0 : ~q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/flash_status_poll.sv
module flash_status_poll
  import fsp_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS = 11,
  localparam int unsigned IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_start,
  input  logic                  op_is_erase,
  input  logic                  busy,
  input  logic                  suspended,
  input  logic                  erase_started,
  input  logic                  error_flag,
  input  logic                  prog_dq7,
  input  logic [NUM_BLOCKS-1:0] erasing_mask,
  input  logic [NUM_BLOCKS-1:0] failed_mask,
  input  logic [IDX_W-1:0]      rd_blk,
  input  logic                  rd_strobe,
  output logic [7:0]            status_word,
  output logic                  array_sel
);
  logic                   rst_n_int;
  fsp_mode_e              mode;
  logic                   hit_erasing;
  logic                   hit_failed;
  logic [FSP_NUM_TOG-1:0] tog_adv;
  logic [FSP_NUM_TOG-1:0] tog_q;
  logic                   alt_region;
  logic                   poll_bit;

  fsp_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  fsp_mode_decode mode_i (
    .busy       (busy),
    .suspended  (suspended),
    .error_flag (error_flag),
    .mode       (mode)
  );

  fsp_block_lookup #(.NUM_BLOCKS(NUM_BLOCKS)) lookup_i (
    .erasing_mask (erasing_mask),
    .failed_mask  (failed_mask),
    .rd_blk       (rd_blk),
    .hit_erasing  (hit_erasing),
    .hit_failed   (hit_failed)
  );

  // Block region in which the alternate toggle advances.
  always_comb begin
    unique case (mode)
      FSP_ACTIVE: alt_region = op_is_erase & hit_erasing;
      FSP_SUSP:   alt_region = op_is_erase & hit_erasing;
      FSP_FAULT:  alt_region = op_is_erase & hit_failed;
      default:    alt_region = 1'b0;
    endcase
  end

  always_comb begin
    tog_adv[FSP_TOG_MAIN] = rd_strobe & (mode == FSP_ACTIVE);
    tog_adv[FSP_TOG_ALT]  = rd_strobe & alt_region;
  end

  for (genvar gt = 0; gt < FSP_NUM_TOG; gt++) begin : g_tog
    fsp_toggle_bit tog_i (
      .clk   (clk),
      .rst_n (rst_n_int),
      .clr   (op_start),
      .adv   (tog_adv[gt]),
      .q     (tog_q[gt])
    );
  end

  assign poll_bit = op_is_erase ? 1'b0 : ~prog_dq7;

  always_comb begin
    status_word = 8'h00;
    array_sel   = 1'b0;
    unique case (mode)
      FSP_ACTIVE, FSP_FAULT: begin
        status_word[FSP_BIT_POLL]   = poll_bit;
        status_word[FSP_BIT_TOG]    = tog_q[FSP_TOG_MAIN];
        status_word[FSP_BIT_ERR]    = error_flag;
        status_word[FSP_BIT_TIMER]  = op_is_erase & erase_started;
        status_word[FSP_BIT_ALTTOG] = tog_q[FSP_TOG_ALT];
      end
      FSP_SUSP: begin
        if (hit_erasing) begin
          status_word[FSP_BIT_POLL]   = 1'b1;
          status_word[FSP_BIT_TOG]    = tog_q[FSP_TOG_MAIN];
          status_word[FSP_BIT_TIMER]  = op_is_erase & erase_started;
          status_word[FSP_BIT_ALTTOG] = tog_q[FSP_TOG_ALT];
        end else begin
          array_sel = 1'b1;
        end
      end
      default: array_sel = 1'b1;
    endcase
  end
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker #(
  parameter int unsigned NUM_BLOCKS = 11,
  localparam int unsigned IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  op_start,
  input logic                  op_is_erase,
  input logic                  busy,
  input logic                  suspended,
  input logic                  erase_started,
  input logic                  error_flag,
  input logic                  prog_dq7,
  input logic [NUM_BLOCKS-1:0] erasing_mask,
  input logic [NUM_BLOCKS-1:0] failed_mask,
  input logic [IDX_W-1:0]      rd_blk,
  input logic                  rd_strobe,
  input logic [7:0]            status_word,
  input logic                  array_sel
);
  logic susp_only;
  assign susp_only = suspended & ~busy & ~error_flag;

  AST_IDLE_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !suspended && !error_flag) |-> (array_sel && status_word == 8'h00)); // R1

  AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_is_erase) |-> (!array_sel && status_word[7] == !prog_dq7)); // R2

  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_is_erase) |-> (status_word[7] == 1'b0)); // R3

  AST_BUSY_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy && rd_strobe && !op_start) && busy)
      |-> (status_word[6] != $past(status_word[6]))); // R4

  AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_only && $past(susp_only && !op_start) && !array_sel && $past(!array_sel))
      |-> (status_word[6] == $past(status_word[6]))); // R5

  AST_ERR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!array_sel) |-> (status_word[5] == error_flag)); // R7

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[4] == 1'b0 && status_word[1] == 1'b0 && status_word[0] == 1'b0)); // R11

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_start) && busy && op_is_erase)
      |-> (status_word[6] == 1'b0 && status_word[2] == 1'b0)); // R12
endmodule

bind flash_status_poll fsp_checker #(.NUM_BLOCKS(NUM_BLOCKS)) chk_i (.*);

// File: tb/flash_status_poll_tb_top.sv
module flash_status_poll_tb_top;
  localparam int unsigned NB    = 11;
  localparam int unsigned IW    = $clog2(NB);
  localparam time         CLK_P = 5ns;

  typedef struct packed {
    logic          er;
    logic          bsy;
    logic          sus;
    logic          st;
    logic          err;
    logic          dq7;
    logic [NB-1:0] emask;
    logic [NB-1:0] fmask;
    logic [IW-1:0] blk;
    logic          xsel;
    logic [7:0]    xword;
    logic [7:0]    xmask;
  } vec_t;

  localparam int NV = 10;
  // erasing blocks 1,2 ; failed block 2 ; mask hides toggle bits 6 and 2
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,11'h006,11'h004,4'd1,1'b1,8'h00,8'hFF}, // R1 idle
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,11'h006,11'h004,4'd3,1'b0,8'h00,8'hBB}, // R2 dq7=1
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,11'h006,11'h004,4'd3,1'b0,8'h80,8'hBB}, // R2 dq7=0
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,11'h006,11'h004,4'd1,1'b0,8'h00,8'hBB}, // R3 R8 not started
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,11'h006,11'h004,4'd7,1'b0,8'h08,8'hBB}, // R8 started
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,11'h006,11'h004,4'd1,1'b0,8'h88,8'hBB}, // R6 inside
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,11'h006,11'h004,4'd5,1'b1,8'h00,8'hFF}, // R6 outside
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,11'h006,11'h004,4'd2,1'b0,8'h28,8'hBB}, // R7 erase error
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,11'h000,11'h000,4'd0,1'b0,8'hA0,8'hBB}, // R7 program error
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,11'h006,11'h004,4'd12,1'b1,8'h00,8'hFF} // R6 index out of range
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          op_start, op_is_erase, busy, suspended, erase_started, error_flag, prog_dq7;
  logic [NB-1:0] erasing_mask, failed_mask;
  logic [IW-1:0] rd_blk;
  logic          rd_strobe;
  logic [7:0]    status_word;
  logic          array_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic exp6, exp2;

  always #(CLK_P/2) clk = ~clk;

  flash_status_poll #(.NUM_BLOCKS(NB)) dut_i (.*);

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_state(input logic er, input logic bsy, input logic sus, input logic st,
                           input logic err, input logic dq7, input logic [IW-1:0] blk);
    @(negedge clk);
    op_is_erase = er; busy = bsy; suspended = sus; erase_started = st;
    error_flag = err; prog_dq7 = dq7; rd_blk = blk;
    #1;
  endtask

  task automatic strobe();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
    #1;
  endtask

  task automatic pulse_start();
    @(negedge clk); op_start = 1'b1;
    @(negedge clk); op_start = 1'b0;
    #1;
  endtask

  task automatic check_tog(input string req);
    check(req, {7'd0, status_word[6], status_word[2]}, {7'd0, exp6, exp2});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; op_start = 0; op_is_erase = 0; busy = 0; suspended = 0;
    erase_started = 0; error_flag = 0; prog_dq7 = 0; rd_strobe = 0;
    erasing_mask = 11'h006; failed_mask = 11'h004; rd_blk = '0;
    exp6 = 0; exp2 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R13 reset state of toggles, read as program status
    set_state(0, 1, 0, 0, 0, 0, 4'd1);
    check_tog("R13 reset toggles");

    // static bits across states (R11 via mask covering bits 4,1,0)
    for (int i = 0; i < NV; i++) begin
      erasing_mask = VECS[i].emask; failed_mask = VECS[i].fmask;
      set_state(VECS[i].er, VECS[i].bsy, VECS[i].sus, VECS[i].st,
                VECS[i].err, VECS[i].dq7, VECS[i].blk);
      check($sformatf("R1/R2/R3/R6/R7/R8/R11 vector %0d", i),
            {array_sel, status_word & VECS[i].xmask}, {VECS[i].xsel, VECS[i].xword});
    end
    erasing_mask = 11'h006; failed_mask = 11'h004;

    // R4 program: bit 6 toggles, bit 2 stays (R9)
    set_state(0, 1, 0, 0, 0, 1, 4'd1);
    for (int k = 0; k < 3; k++) begin
      strobe();
      exp6 = ~exp6;
      check_tog("R4 R9 program toggles");
    end

    // R12 restart clears
    pulse_start(); exp6 = 0; exp2 = 0;
    check_tog("R12 clear on start");

    // R9 erase busy, erasing block then other block
    set_state(1, 1, 0, 1, 0, 0, 4'd1);
    strobe(); exp6 = ~exp6; exp2 = ~exp2;
    check_tog("R9 R4 erase in erasing block");
    set_state(1, 1, 0, 1, 0, 0, 4'd5);
    strobe(); exp6 = ~exp6;
    check_tog("R9 erase outside erasing block");

    // R5 suspend: bit 6 holds, bit 2 still toggles (R9)
    set_state(1, 0, 1, 1, 0, 0, 4'd2);
    strobe(); exp2 = ~exp2;
    check_tog("R5 R9 suspend in erasing block");
    strobe(); exp2 = ~exp2;
    check_tog("R5 R9 suspend second read");

    // R10 error: toggle only on failed block
    set_state(1, 0, 0, 1, 1, 0, 4'd2);
    strobe(); exp2 = ~exp2;
    check_tog("R10 failed block toggles");
    set_state(1, 0, 0, 1, 1, 0, 4'd1);
    strobe();
    check_tog("R10 good block holds");

    // R12 start wins over strobe in same cycle
    set_state(1, 1, 0, 1, 0, 0, 4'd1);
    strobe(); exp6 = ~exp6; exp2 = ~exp2;
    @(negedge clk); op_start = 1'b1; rd_strobe = 1'b1;
    @(negedge clk); op_start = 1'b0; rd_strobe = 1'b0;
    #1; exp6 = 0; exp2 = 0;
    check_tog("R12 start priority over strobe");

    finish_run();
  end
endmodule